// File: doc/BRIEF.md
# Brushless Motor Block-Commutation Encoder

This block turns a mechanical shaft angle in whole degrees (0 to 359) into the three block-commutation signals U, V and W that drive a brushless DC motor. First it adds a fixed zero offset to the raw angle. It then shifts the result by two advance amounts. The static shift is picked by a 2-bit code. The dynamic shift is a 6-bit value that can be reloaded at any time through a write strobe. Next it multiplies the result by the motor's pole-pair count. The electrical angle that results is split into six 60-degree sectors, and each sector gives one U/V/W pattern.

A direction input sets the sign of both shifts. When the motor turns one way the shifts move the angle forward, and when it turns the other way they move it back. The direction input is asynchronous, so it passes through a two-stage synchroniser. Any change of direction clears the dynamic shift, and the controller must write it again. An error input blanks all three outputs.

Top module: `bldc_commutator`

## Requirements
- R1: The zero offset is added to the raw angle modulo 360. For example, raw 300 with offset 100 is treated as 40 degrees.
- R2: The pole-pair count is the 3-bit code plus one for codes 0 to 4. Codes 5, 6 and 7 all select six pole pairs.
- R3: The static shift is set by the 2-bit code: 0 gives 0 degrees, 1 gives 2 degrees, 2 gives 4 degrees and 3 gives 8 degrees. This shift is always applied.
- R4: On a clock edge with the write strobe high and no direction change detected, the dynamic shift takes the 6-bit value (0 to 63 degrees). At all other edges it holds its value.
- R5: With direction 0, static plus dynamic shift is added to the offset angle. With direction 1 it is subtracted. Both results wrap modulo 360, so a negative result folds back into 0 to 359.
- R6: A change on the direction input resets the dynamic shift to zero, and this takes priority over a write that arrives at the same edge.
- R7: A direction change set up before rising edge N appears on the outputs after edge N+2. Changes on the angle, offset, codes, dynamic shift and error flag appear after the next rising edge.
- R8: The electrical angle e equals the shifted mechanical angle times the pole-pair count, modulo 360. U is high for e in [0,180). V is high for e in [120,300). W is high for e in [240,360) or [0,60). Each 60-degree sector therefore differs from its neighbour in exactly one output.
- R9: While the error input is high, U, V and W are all 0 from the next edge on.
- R10: During reset U, V and W are 0, the dynamic shift is 0 and the synchronised direction is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| angle_in | input | 9 | Raw mechanical angle, 0 to 359 |
| zero_off | input | 9 | Zero offset, 0 to 359 |
| pole_code | input | 3 | Pole-pair code |
| stat_code | input | 2 | Static shift code |
| dyn_val | input | 6 | Dynamic shift value, in degrees |
| dyn_wr | input | 1 | Write strobe for the dynamic shift |
| dir_in | input | 1 | Rotation direction, asynchronous |
| err_in | input | 1 | Error flag; blanks the outputs |
| phase_u | output | 1 | Commutation output U |
| phase_v | output | 1 | Commutation output V |
| phase_w | output | 1 | Commutation output W |

## Verification
Each test is checked against a reference model built on the requirements. A full sweep of all 360 angles with two pole pairs walks through every sector boundary. A single angle is then run through all eight pole codes. These give different sectors for one to five pairs and the same sector for the three saturating codes, so a decode error shows up. Static codes are tried at an angle near a sector edge, where only the 8-degree shift crosses it. Subtraction is tried close to zero, where a missing wrap gives a wrong sector. The direction test samples the outputs after each of the three edges that follow a change. The step back to the first direction then tells a cleared dynamic shift apart from a retained one.

// File: rtl/bldc_commutator.sv
module bldc_commutator #(
  parameter int AW   = 9,
  parameter int DW   = 6,
  parameter int FULL = 360
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] angle_in,
  input  logic [AW-1:0] zero_off,
  input  logic [2:0]    pole_code,
  input  logic [1:0]    stat_code,
  input  logic [DW-1:0] dyn_val,
  input  logic          dyn_wr,
  input  logic          dir_in,
  input  logic          err_in,
  output logic          phase_u,
  output logic          phase_v,
  output logic          phase_w
);
  localparam int EW = AW + 3;
  localparam logic [EW-1:0] FULL_E = EW'(FULL);
  localparam logic [EW-1:0] SECT_E = EW'(FULL / 6);

  logic          dir_s1, dir_s2, started_q;
  logic [DW-1:0] dyn_q;
  logic [EW-1:0] base_sum, base, shift, fwd, back, mech, pairs, prod, elec;
  logic [2:0]    sector;
  logic [2:0]    uvw_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_s1 <= 1'b0;
      dir_s2 <= 1'b0;
    end else begin
      dir_s1 <= dir_in;
      dir_s2 <= dir_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                dyn_q <= '0;
    else if (dir_s1 != dir_s2) dyn_q <= '0;
    else if (dyn_wr)           dyn_q <= dyn_val;

  assign base_sum = EW'(angle_in) + EW'(zero_off);
  assign base     = (base_sum >= FULL_E) ? base_sum - FULL_E : base_sum;

  logic [EW-1:0] stat_deg;
  always_comb
    case (stat_code)
      2'd0:    stat_deg = EW'(0);
      2'd1:    stat_deg = EW'(2);
      2'd2:    stat_deg = EW'(4);
      default: stat_deg = EW'(8);
    endcase

  assign shift = stat_deg + EW'(dyn_q);
  assign fwd   = (base + shift >= FULL_E) ? base + shift - FULL_E : base + shift;
  assign back  = (base >= shift) ? base - shift : base + FULL_E - shift;
  assign mech  = dir_s2 ? back : fwd;
  assign pairs = (pole_code >= 3'd5) ? EW'(6) : EW'(pole_code) + EW'(1);
  assign prod  = mech * pairs;

  always_comb begin
    elec = prod;
    for (int i = 0; i < 6; i++)
      if (elec >= FULL_E) elec = elec - FULL_E;
  end

  always_comb begin
    sector = 3'd5;
    for (int k = 4; k >= 0; k--)
      if (elec < SECT_E * EW'(k + 1)) sector = 3'(k);
  end

  always_comb
    case (sector)
      3'd0:    uvw_d = 3'b101;
      3'd1:    uvw_d = 3'b100;
      3'd2:    uvw_d = 3'b110;
      3'd3:    uvw_d = 3'b010;
      3'd4:    uvw_d = 3'b011;
      default: uvw_d = 3'b001;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {phase_u, phase_v, phase_w} <= 3'b000;
      started_q <= 1'b0;
    end else begin
      {phase_u, phase_v, phase_w} <= err_in ? 3'b000 : uvw_d;
      started_q <= 1'b1;
    end

  assert_err_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_in) && started_q |-> {phase_u, phase_v, phase_w} == 3'b000);

  assert_valid_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
    started_q && !$past(err_in) |->
      ({phase_u, phase_v, phase_w} != 3'b000) && ({phase_u, phase_v, phase_w} != 3'b111));

  assert_dyn_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dir_s1 != dir_s2 |=> dyn_q == '0);

  assert_dyn_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dyn_wr && dir_s1 == dir_s2 |=> dyn_q == $past(dyn_val));

  assert_dyn_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dyn_wr && dir_s1 == dir_s2 |=> $stable(dyn_q));
endmodule

// File: tb/bldc_commutator_tb.sv
module bldc_commutator_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] angle_in = '0, zero_off = '0;
  logic [2:0] pole_code = '0;
  logic [1:0] stat_code = '0;
  logic [5:0] dyn_val = '0;
  logic       dyn_wr = 1'b0, dir_in = 1'b0, err_in = 1'b0;
  logic       phase_u, phase_v, phase_w;

  int total = 0, bad = 0;
  int dyn_m = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bldc_commutator dut_i (
    .clk(clk), .rst_n(rst_n), .angle_in(angle_in), .zero_off(zero_off),
    .pole_code(pole_code), .stat_code(stat_code), .dyn_val(dyn_val),
    .dyn_wr(dyn_wr), .dir_in(dir_in), .err_in(err_in),
    .phase_u(phase_u), .phase_v(phase_v), .phase_w(phase_w));

  function automatic logic [2:0] model(int ang, int z, int pc, int sc, int dy, bit d);
    int m, sh, pp, e;
    m  = (ang + z) % 360;
    sh = (sc == 0) ? 0 : (1 << sc);
    sh = sh + dy;
    m  = d ? (m - sh + 360) % 360 : (m + sh) % 360;
    pp = (pc > 4) ? 6 : pc + 1;
    e  = (m * pp) % 360;
    return {e < 180, (e >= 120) && (e < 300), (e >= 240) || (e < 60)};
  endfunction

  function automatic logic [2:0] expect_now();
    return model(angle_in, zero_off, pole_code, stat_code, dyn_m, dir_in);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [2:0] exp);
    total++;
    if ({phase_u, phase_v, phase_w} !== exp) begin
      bad++;
      $display("FAIL %s: uvw=%b expected=%b (angle=%0d)", req, {phase_u, phase_v, phase_w}, exp, angle_in);
    end
  endtask

  task automatic write_dyn(int v);
    dyn_val = 6'(v);
    dyn_wr = 1'b1;
    tick();
    dyn_wr = 1'b0;
    dyn_m = v;
  endtask

  task automatic t_reset();
    chk("R10", 3'b000);
    rst_n = 1'b1;
    tick();
    chk("R10", expect_now());
  endtask

  task automatic t_sweep();
    pole_code = 3'd1;
    for (int a = 0; a < 360; a++) begin
      angle_in = 9'(a);
      tick();
      chk("R8", expect_now());
    end
    pole_code = 3'd0;
  endtask

  task automatic t_zero();
    angle_in = 9'd300; zero_off = 9'd100;
    tick();
    chk("R1", expect_now());
    angle_in = 9'd359; zero_off = 9'd359;
    tick();
    chk("R1", expect_now());
    zero_off = 9'd0;
  endtask

  task automatic t_poles();
    angle_in = 9'd100;
    for (int c = 0; c < 8; c++) begin
      pole_code = 3'(c);
      tick();
      chk("R2", expect_now());
    end
    pole_code = 3'd0;
  endtask

  task automatic t_static();
    angle_in = 9'd55;
    for (int c = 0; c < 4; c++) begin
      stat_code = 2'(c);
      tick();
      chk("R3", expect_now());
    end
    dir_in = 1'b1;
    repeat (3) tick();
    dyn_m = 0;
    angle_in = 9'd5;
    tick();
    chk("R5", expect_now());
    dir_in = 1'b0;
    repeat (3) tick();
    stat_code = 2'd0;
  endtask

  task automatic t_dynamic();
    angle_in = 9'd0;
    write_dyn(63);
    tick();
    chk("R4", expect_now());
    dyn_val = 6'd0;
    repeat (2) tick();
    chk("R4", expect_now());
    write_dyn(0);
  endtask

  task automatic t_direction();
    angle_in = 9'd50; stat_code = 2'd3;
    write_dyn(20);
    tick();
    chk("R5", 3'b100);
    dir_in = 1'b1;
    tick(); chk("R7", 3'b100);
    tick(); chk("R7", 3'b100);
    dyn_m = 0;
    tick(); chk("R7", expect_now());
    dir_in = 1'b0;
    repeat (3) tick();
    chk("R6", 3'b101);
    stat_code = 2'd0;
  endtask

  task automatic t_error();
    angle_in = 9'd200;
    err_in = 1'b1;
    tick();
    chk("R9", 3'b000);
    err_in = 1'b0;
    tick();
    chk("R9", expect_now());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_sweep();
    t_zero();
    t_poles();
    t_static();
    t_dynamic();
    t_direction();
    t_error();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule